// File: doc/BRIEF.md
# Infrared SIR line stage

This block sits between a UART and the outside world. It can steer the UART's serial lines either to a pair of plain wired pins or through an infrared path that uses return-to-zero pulses. In infrared mode, the transmit side turns every zero bit of the UART's NRZ stream into a short high pulse on an LED drive output. A one bit sends no pulse. The receive side watches a photodiode input. Each pulse it sees becomes a low level for one bit period, which is what the UART receiver expects.

A single mode input selects the path. In infrared mode the wired transmit pin is parked at its idle high level and the wired receive pin is shut out. In wired mode the LED stays dark, the photodiode is ignored, and both wired pins pass straight through. Bit timing comes from the UART's own 16x baud sub-tick, a one-cycle strobe that the UART already generates. This lets the stage follow any bit rate up to 115.2 kbit/s and beyond, with no divider of its own. All outputs are registered.

Top module: `irda_sir_bridge`

## Requirements
- R1: While `rst` is high, `led_drv` is 0 and `wire_txd` and `uart_rxd` are 1, whatever the other inputs are.
- R2: With `ir_en` = 1, a UART bit begins on the sub-tick where `uart_txd` differs from its value at the previous sub-tick, or after OVERSAMPLE sub-ticks at a steady level. Each bit whose value is 0 produces exactly one high pulse on `led_drv`. The pulse starts the cycle after the bit's first sub-tick and lasts PULSE_TICKS sub-tick intervals. Bits of value 1 produce no pulse.
- R3: With `ir_en` = 0, `led_drv` is 0 from the next cycle on, even while `uart_txd` carries data.
- R4: With `ir_en` = 1, `wire_txd` is 1 from the next cycle on, even while `uart_txd` carries zero bits.
- R5: With `ir_en` = 1, activity on `wire_rxd` has no effect on `uart_rxd`.
- R6: With `ir_en` = 0, `wire_txd` equals `uart_txd` and `uart_rxd` equals `wire_rxd`, each one clock later.
- R7: In infrared mode, `pd_in` is active high and passes through SYNC_STAGES flops. `uart_rxd` falls SYNC_STAGES+2 cycles after `pd_in` rises. The OVERSAMPLE sub-tick intervals counted here begin at the first sub-tick after the edge is detected. `uart_rxd` stays low until those intervals have all elapsed, and rises one cycle after the sub-tick that closes them.
- R8: A new pulse edge that arrives while `uart_rxd` is low restarts the hold. Zero bits one bit period apart therefore give one unbroken low level.
- R9: With `led_drv` looped back into `pd_in`, sampling `uart_rxd` in the middle of each bit recovers the start bit and data bits sent on `uart_txd`.
- R10: With `ir_en` = 0, pulses on `pd_in` have no effect on `uart_rxd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_en | input | 1 | 1 selects the infrared path, 0 the wired pins |
| baud_tick | input | 1 | One-cycle strobe at 16x (OVERSAMPLE x) the bit rate |
| uart_txd | input | 1 | NRZ transmit stream from the UART |
| led_drv | output | 1 | LED drive, high during a pulse |
| wire_txd | output | 1 | Wired transmit pin |
| wire_rxd | input | 1 | Wired receive pin |
| pd_in | input | 1 | Photodiode input, high during a received pulse |
| uart_rxd | output | 1 | NRZ receive stream to the UART |

## Verification
The bench builds the block with its defaults: 16 sub-ticks per bit, 3-tick pulses and a two-flop synchronizer. It issues a sub-tick every fourth clock, so one bit lasts 64 cycles. With these values the synchronizer delay (three cycles) is shorter than one sub-tick interval, so the hold length can be predicted to the exact cycle. It is 65 cycles for a single pulse and 129 for two back-to-back zero bits. The bench also uses frames of all zeros, which drive the encoder's phase counter through its wrap-around on repeated equal bits. A looped-back mode drives the decoder from the encoder's own pulses.

// File: rtl/sir_pkg.sv
package sir_pkg;

  localparam int unsigned SIR_OVERSAMPLE_DEF = 16;
  localparam int unsigned SIR_PULSE_DEF      = 3;
  localparam int unsigned SIR_SYNC_DEF       = 2;

  localparam logic SIR_LINE_IDLE = 1'b1;
  localparam logic SIR_LED_DARK  = 1'b0;

  typedef enum logic {
    PATH_WIRED = 1'b0,
    PATH_IR    = 1'b1
  } sir_path_e;

endpackage

// File: rtl/sir_sync.sv
module sir_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[i] <= RESET_VAL;
        else     chain_q[i] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) chain_q[i] <= RESET_VAL;
        else     chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/sir_encoder.sv
module sir_encoder #(
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned PULSE_TICKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic txd,
  output logic led
);

  localparam int unsigned PH_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam int unsigned PC_W = $clog2(PULSE_TICKS + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);
  localparam logic [PC_W-1:0] PC_LOAD = PC_W'(PULSE_TICKS - 1);

  logic [PH_W-1:0] phase_q;
  logic [PC_W-1:0] remain_q;
  logic            prev_txd_q;
  logic            led_q;
  logic            bit_start;

  // A bit starts when the line moved since the last sub-tick, or a full
  // bit period of steady level has gone by.
  assign bit_start = (txd != prev_txd_q) || (phase_q == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase_q    <= '0;
      remain_q   <= '0;
      prev_txd_q <= 1'b1;
      led_q      <= 1'b0;
    end else if (tick) begin
      prev_txd_q <= txd;
      if (bit_start) begin
        phase_q <= '0;
        if (!txd) begin
          led_q    <= 1'b1;
          remain_q <= PC_LOAD;
        end else begin
          led_q    <= 1'b0;
          remain_q <= '0;
        end
      end else begin
        phase_q <= phase_q + 1'b1;
        if (remain_q != '0) begin
          remain_q <= remain_q - 1'b1;
          led_q    <= 1'b1;
        end else begin
          led_q    <= 1'b0;
        end
      end
    end
  end

  assign led = led_q;

  // R2: a pulse can only begin on a sub-tick
  p_led_rise_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(led_q) |-> $past(tick))
    else $error("p_led_rise_on_tick_r2");

  // R2: a pulse only starts for a zero on the line
  p_led_rise_on_zero_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(led_q) |-> !$past(txd))
    else $error("p_led_rise_on_zero_r2");

endmodule

// File: rtl/sir_decoder.sv
module sir_decoder #(
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  input  logic pd,
  output logic nrz
);

  localparam int unsigned RW = $clog2(OVERSAMPLE + 1);
  localparam logic [RW-1:0] HOLD_LOAD = RW'(OVERSAMPLE);

  logic          pd_s;
  logic          pd_d_q;
  logic [RW-1:0] hold_q;
  logic          nrz_q;
  logic          pulse_edge;

  sir_sync #(
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (1'b0)
  ) u_pd_sync (
    .clk (clk),
    .rst (rst),
    .d   (pd),
    .q   (pd_s)
  );

  assign pulse_edge = pd_s && !pd_d_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      // a line already high at enable is not taken as an edge
      pd_d_q <= 1'b1;
      hold_q <= '0;
      nrz_q  <= 1'b1;
    end else begin
      pd_d_q <= pd_s;
      if (pulse_edge) begin
        hold_q <= HOLD_LOAD;
        nrz_q  <= 1'b0;
      end else if (tick) begin
        if (hold_q != '0) hold_q <= hold_q - 1'b1;
        else              nrz_q  <= 1'b1;
      end
    end
  end

  assign nrz = nrz_q;

  // R7: the level drops only on a detected pulse edge
  p_fall_on_edge_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(nrz_q) |-> $past(pulse_edge))
    else $error("p_fall_on_edge_r7");

  // R7: while enabled, release happens on a sub-tick
  p_rise_on_tick_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(nrz_q) && $past(en)) |-> $past(tick))
    else $error("p_rise_on_tick_r7");

  // R10: disabled decoder idles high
  p_idle_when_off_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> nrz_q)
    else $error("p_idle_when_off_r10");

endmodule

// File: rtl/irda_sir_bridge.sv
module irda_sir_bridge
  import sir_pkg::*;
#(
  parameter int unsigned OVERSAMPLE  = SIR_OVERSAMPLE_DEF,
  parameter int unsigned PULSE_TICKS = SIR_PULSE_DEF,
  parameter int unsigned SYNC_STAGES = SIR_SYNC_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic ir_en,
  input  logic baud_tick,
  input  logic uart_txd,
  output logic led_drv,
  output logic wire_txd,
  input  logic wire_rxd,
  input  logic pd_in,
  output logic uart_rxd
);

  sir_path_e path;
  logic      dec_nrz;
  logic      wtx_q;
  logic      urx_q;

  assign path = ir_en ? PATH_IR : PATH_WIRED;

  sir_encoder #(
    .OVERSAMPLE  (OVERSAMPLE),
    .PULSE_TICKS (PULSE_TICKS)
  ) u_enc (
    .clk  (clk),
    .rst  (rst),
    .en   (path == PATH_IR),
    .tick (baud_tick),
    .txd  (uart_txd),
    .led  (led_drv)
  );

  sir_decoder #(
    .OVERSAMPLE  (OVERSAMPLE),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dec (
    .clk  (clk),
    .rst  (rst),
    .en   (path == PATH_IR),
    .tick (baud_tick),
    .pd   (pd_in),
    .nrz  (dec_nrz)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wtx_q <= SIR_LINE_IDLE;
      urx_q <= SIR_LINE_IDLE;
    end else if (path == PATH_IR) begin
      wtx_q <= SIR_LINE_IDLE;
      urx_q <= dec_nrz;
    end else begin
      wtx_q <= uart_txd;
      urx_q <= wire_rxd;
    end
  end

  assign wire_txd = wtx_q;
  assign uart_rxd = urx_q;

  // R4: wired transmit parked while infrared is selected
  p_wire_tx_idle_r4: assert property (@(posedge clk) disable iff (rst)
    $past(ir_en) |-> wire_txd)
    else $error("p_wire_tx_idle_r4");

  // R3: LED dark in wired mode
  p_led_dark_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(ir_en) |-> (led_drv == SIR_LED_DARK))
    else $error("p_led_dark_r3");

  // R6: wired receive passes with one cycle of delay
  p_rx_pass_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(ir_en) |-> (uart_rxd == $past(wire_rxd)))
    else $error("p_rx_pass_r6");

  // R6: wired transmit passes with one cycle of delay
  p_tx_pass_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(ir_en) |-> (wire_txd == $past(uart_txd)))
    else $error("p_tx_pass_r6");

endmodule

// File: tb/irda_sir_bridge_tb.sv
`timescale 1ns/1ps
module irda_sir_bridge_tb;

  localparam int OS  = 16;
  localparam int PT  = 3;
  localparam int SS  = 2;
  localparam int DIV = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic ir_en = 1'b0;
  logic baud_tick = 1'b0;
  logic uart_txd = 1'b1;
  logic wire_rxd = 1'b1;
  logic pd_man = 1'b0;
  logic loop_en = 1'b0;
  logic pd_in;
  logic led_drv, wire_txd, uart_rxd;

  assign pd_in = loop_en ? led_drv : pd_man;

  irda_sir_bridge #(
    .OVERSAMPLE  (OS),
    .PULSE_TICKS (PT),
    .SYNC_STAGES (SS)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .ir_en     (ir_en),
    .baud_tick (baud_tick),
    .uart_txd  (uart_txd),
    .led_drv   (led_drv),
    .wire_txd  (wire_txd),
    .wire_rxd  (wire_rxd),
    .pd_in     (pd_in),
    .uart_rxd  (uart_rxd)
  );

  int div_cnt = 0;
  always @(negedge clk) begin
    if (div_cnt == DIV - 1) begin
      div_cnt   <= 0;
      baud_tick <= 1'b1;
    end else begin
      div_cnt   <= div_cnt + 1;
      baud_tick <= 1'b0;
    end
  end

  int errors = 0;
  int checks = 0;

  // output monitor, sampled at the falling edge
  int led_run = 0, led_pulses = 0, led_bad_w = 0;
  int rx_run = 0, rx_last_low = 0, rx_low_events = 0;
  bit led_prev = 1'b0, rx_prev = 1'b1, wtx_low_seen = 1'b0, led_seen = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (led_drv) begin
        led_run  = led_run + 1;
        led_seen = 1'b1;
      end else if (led_prev) begin
        led_pulses = led_pulses + 1;
        if (led_run != PT * DIV) led_bad_w = led_bad_w + 1;
        led_run = 0;
      end
      led_prev = led_drv;
      if (!uart_rxd) rx_run = rx_run + 1;
      else if (!rx_prev) begin
        rx_last_low   = rx_run;
        rx_low_events = rx_low_events + 1;
        rx_run        = 0;
      end
      rx_prev = uart_rxd;
      if (ir_en && !wire_txd) wtx_low_seen = 1'b1;
    end
  end

  task automatic clear_mon();
    led_run = 0; led_pulses = 0; led_bad_w = 0; led_prev = 1'b0; led_seen = 1'b0;
    rx_run = 0; rx_last_low = 0; rx_low_events = 0; rx_prev = 1'b1;
    wtx_low_seen = 1'b0;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_ticks(int n);
    repeat (n) @(posedge clk iff baud_tick);
    #1;
  endtask

  task automatic send_frame(logic [7:0] data, bit check_loop);
    logic [9:0] bits;
    bits = {1'b1, data, 1'b0};
    wait_ticks(1);
    for (int i = 0; i < 10; i++) begin
      uart_txd = bits[i];
      wait_ticks(OS / 2);
      if (check_loop && i < 9) chk("R9", $sformatf("bit %0d", i), uart_rxd, bits[i]);
      wait_ticks(OS / 2);
    end
    uart_txd = 1'b1;
    wait_ticks(2 * OS);
  endtask

  task automatic t_reset();
    rst = 1'b1; uart_txd = 1'b0; wire_rxd = 1'b0; pd_man = 1'b1; ir_en = 1'b0;
    repeat (6) step();
    chk("R1", "led_drv in reset", led_drv, 0);
    chk("R1", "wire_txd in reset", wire_txd, 1);
    chk("R1", "uart_rxd in reset", uart_rxd, 1);
    uart_txd = 1'b1; wire_rxd = 1'b1; pd_man = 1'b0;
    step();
    rst = 1'b0;
    step();
  endtask

  task automatic t_wired();
    ir_en = 1'b0;
    step();
    uart_txd = 1'b0; wire_rxd = 1'b0;
    step();
    chk("R6", "wire_txd follows 0", wire_txd, 0);
    chk("R6", "uart_rxd follows 0", uart_rxd, 0);
    uart_txd = 1'b1; wire_rxd = 1'b1;
    step();
    chk("R6", "wire_txd follows 1", wire_txd, 1);
    chk("R6", "uart_rxd follows 1", uart_rxd, 1);
  endtask

  task automatic t_wired_ignore();
    int lows = 0;
    ir_en = 1'b0;
    clear_mon();
    send_frame(8'h00, 1'b0);
    chk("R3", "led_drv active in wired mode", led_seen, 0);
    for (int i = 0; i < 4; i++) begin
      pd_man = 1'b1;
      repeat (10) begin step(); if (!uart_rxd) lows++; end
      pd_man = 1'b0;
      repeat (10) begin step(); if (!uart_rxd) lows++; end
    end
    chk("R10", "uart_rxd lows from pd_in in wired mode", lows, 0);
  endtask

  task automatic t_encode(logic [7:0] data);
    ir_en = 1'b1; loop_en = 1'b0; pd_man = 1'b0;
    repeat (3) step();
    clear_mon();
    send_frame(data, 1'b0);
    chk("R2", $sformatf("pulse count for %02h", data), led_pulses, 1 + 8 - $countones(data));
    chk("R2", $sformatf("bad pulse widths for %02h", data), led_bad_w, 0);
    chk("R4", "wire_txd low in infrared mode", wtx_low_seen, 0);
  endtask

  task automatic t_rx_block();
    int lows = 0;
    ir_en = 1'b1; pd_man = 1'b0;
    repeat (3) step();
    for (int i = 0; i < 40; i++) begin
      wire_rxd = ~wire_rxd;
      step();
      if (!uart_rxd) lows++;
    end
    wire_rxd = 1'b1;
    chk("R5", "uart_rxd lows from wire_rxd", lows, 0);
  endtask

  task automatic t_decode_single();
    ir_en = 1'b1; loop_en = 1'b0;
    wait_ticks(2);
    clear_mon();
    pd_man = 1'b1;
    wait_ticks(PT);
    pd_man = 1'b0;
    wait_ticks(2 * OS);
    chk("R7", "low events for one pulse", rx_low_events, 1);
    chk("R7", "low length for one pulse", rx_last_low, (OS + 1) * DIV - (SS + 1));
    chk("R7", "uart_rxd back high", uart_rxd, 1);
  endtask

  task automatic t_decode_pair();
    ir_en = 1'b1; loop_en = 1'b0;
    wait_ticks(2);
    clear_mon();
    pd_man = 1'b1;
    wait_ticks(PT);
    pd_man = 1'b0;
    wait_ticks(OS - PT);
    pd_man = 1'b1;
    wait_ticks(PT);
    pd_man = 1'b0;
    wait_ticks(2 * OS);
    chk("R8", "low events for two pulses", rx_low_events, 1);
    chk("R8", "low length for two pulses", rx_last_low, (2 * OS + 1) * DIV - (SS + 1));
  endtask

  task automatic t_loopback(logic [7:0] data);
    ir_en = 1'b1; pd_man = 1'b0; loop_en = 1'b1;
    repeat (3) step();
    send_frame(data, 1'b1);
    chk("R9", "idle after frame", uart_rxd, 1);
    loop_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_wired();
    t_wired_ignore();
    t_encode(8'h00);
    t_encode(8'hA5);
    t_rx_block();
    t_decode_single();
    t_decode_pair();
    t_loopback(8'h3C);
    t_loopback(8'h81);
    finish_run();
  end

endmodule